// File: doc/BRIEF.md
# Encoded Power-of-Two Clock Prescaler

This block turns one of two source clock streams into a slower clock-enable for a downstream peripheral. Both sources reach the block as tick strobes in the fast register clock domain. One comes from a PLL output and the other from the system bus clock. A select bit picks the source, and after reset it picks the bus clock. The block counts the ticks of the selected source and raises its enable output once for every one, two or four of them. A full-speed serial device that needs 48 MHz can therefore run from a faster PLL, once software has reprogrammed the select bit and the divisor after reset.

The divide ratio is held as a code, not as a count. Code 0 divides by one, code 1 divides by two and code 2 divides by four. Any other code is refused, and a sticky error bit records the refusal. A new code does not act at once. It takes effect at the next output-period boundary, so no output period is ever cut short or stretched. Changing the source restarts the divide counter and keeps the enable low for two register-clock cycles.

Software reaches two 32-bit word registers through a plain write port with byte strobes and a combinational read port. The divisor register is at word 0. The control register is at word 1.

Top module: `pow2_clk_prescaler`

## Requirements
- R1: After reset, word 0 reads 0x00000000, which is divisor code 0 (divide by one). Word 1 reads 0x00000000, which means the bus clock is selected and the error bit is clear.
- R2: With code 0 active, `outEn` follows the selected source tick in every cycle. It is high continuously while that tick is held high.
- R3: With code 1 or code 2 active, `outEn` is high for exactly one cycle on every 2nd or every 4th selected tick.
- R4: Writing a code above 2 to word 0 with byte lane 0 enabled leaves the stored code unchanged. It also sets the sticky error bit, which is bit 8 of word 1.
- R5: The error bit stays set until a write to word 1 with byte lane 1 enabled and data bit 8 set to 1. That write clears it.
- R6: Bits 31:8 of word 0 and all bits of word 1 other than bits 0 and 8 read back as zero, whatever was written to them. Any other word address reads zero and ignores writes.
- R7: Only byte lane 0 can change the divisor code. A write to word 0 with lane 0 disabled changes nothing.
- R8: A new divisor code takes effect only at an output-period boundary. With the source tick held high, every gap between enable pulses is 1, 2 or 4 cycles.
- R9: Bit 0 of word 1 selects the source: 1 selects the PLL tick and 0 selects the bus tick. Only ticks of the selected source advance the divider.
- R10: A write that changes bit 0 of word 1 restarts the divider and holds `outEn` low for the next two cycles. A write that leaves bit 0 unchanged does not restart the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counting clock |
| rstN | input | 1 | Active-low synchronous reset |
| pllTick | input | 1 | Tick strobe of the PLL source |
| busTick | input | 1 | Tick strobe of the bus-clock source |
| regAddr | input | AddrW | Word address for read and write |
| regWrEn | input | 1 | Write request |
| regByteEn | input | DataW/8 | Byte-lane write strobes |
| regWrData | input | DataW | Write data |
| regRdData | output | DataW | Read data for `regAddr` (combinational) |
| outEn | output | 1 | Divided clock-enable in the source domain |

## Verification
A wrong divide counter or a wrong active divisor shows up on `outEn` within one output period, which is at most four selected ticks. A pulse then arrives early, late or twice in a row, and the per-cycle reference model and the gap check both catch it. A corrupted code, select bit or error flag shows up on the next read of the word that holds it. A missed restart shows up in the first or second cycle after the select write, when `outEn` goes high during the blanking window.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int unsigned CodeW = 8;
  localparam int unsigned MaxCode = 2;
  localparam int unsigned CntW = (MaxCode > 0) ? MaxCode : 1;
  localparam int unsigned BlankCycles = 2;
  localparam int unsigned BlankW = 2;
  localparam int unsigned AddrDivWord = 0;
  localparam int unsigned AddrCtlWord = 1;
  localparam int unsigned SelBit = 0;
  localparam int unsigned ErrBit = 8;

  typedef logic [CntW-1:0] cnt_t;

  // strobes passed from control to datapath
  typedef struct packed {
    logic tick;
    logic restart;
    cnt_t nextLast;
  } divStrobe_t;

  function automatic logic codeLegal(input logic [CodeW-1:0] code);
    return code <= CodeW'(MaxCode);
  endfunction

  // terminal count for a legal code: divide by 2**code
  function automatic cnt_t codeToLast(input logic [CodeW-1:0] code);
    cnt_t r;
    r = '0;
    for (int i = 0; i <= int'(MaxCode); i++) begin
      if (code == CodeW'(i)) r = cnt_t'((1 << i) - 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/presc_ctrl.sv
module presc_ctrl
  import presc_pkg::*;
#(
  parameter int unsigned DataW = 32,
  parameter int unsigned AddrW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pllTick,
  input  logic               busTick,
  input  logic [AddrW-1:0]   regAddr,
  input  logic               regWrEn,
  input  logic [DataW/8-1:0] regByteEn,
  input  logic [DataW-1:0]   regWrData,
  output logic [DataW-1:0]   regRdData,
  output divStrobe_t         strobe
);
  localparam int unsigned Lanes = DataW / 8;
  localparam int unsigned SelLane = SelBit / 8;
  localparam int unsigned ErrLane = ErrBit / 8;

  logic [CodeW-1:0] divCode;
  logic             srcSel;
  logic             errFlag;
  logic [Lanes-1:0] laneWr;

  for (genvar b = 0; b < Lanes; b++) begin : gLane
    assign laneWr[b] = regWrEn & regByteEn[b];
  end

  logic hitDiv, hitCtl;
  assign hitDiv = (regAddr == AddrW'(AddrDivWord));
  assign hitCtl = (regAddr == AddrW'(AddrCtlWord));

  logic [CodeW-1:0] codeIn;
  logic divWrite, codeOk, selWrite, selChange, errClr;
  assign codeIn    = regWrData[CodeW-1:0];
  assign codeOk    = codeLegal(codeIn);
  assign divWrite  = hitDiv & laneWr[0];
  assign selWrite  = hitCtl & laneWr[SelLane];
  assign selChange = selWrite & (regWrData[SelBit] != srcSel);
  assign errClr    = hitCtl & laneWr[ErrLane] & regWrData[ErrBit];

  logic unusedIn;
  assign unusedIn = ^{regWrData, regByteEn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCode <= '0;
      srcSel  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (divWrite && codeOk) divCode <= codeIn;
      if (selWrite) srcSel <= regWrData[SelBit];
      if (divWrite && !codeOk) errFlag <= 1'b1;
      else if (errClr) errFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (hitDiv) begin
      regRdData[CodeW-1:0] = divCode;
    end else if (hitCtl) begin
      regRdData[SelBit] = srcSel;
      regRdData[ErrBit] = errFlag;
    end
  end

  assign strobe.tick     = srcSel ? pllTick : busTick;
  assign strobe.restart  = selChange;
  assign strobe.nextLast = codeToLast(divCode);

  assert_invalid_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (divWrite && !codeOk) |=> ($stable(divCode) && errFlag));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);

  assert_restart_flips_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (srcSel != $past(srcSel)));
endmodule

// File: rtl/presc_divpath.sv
module presc_divpath
  import presc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  divStrobe_t strobe,
  output logic       outEn
);
  cnt_t              cnt;
  cnt_t              activeLast;
  logic [BlankW-1:0] blankCnt;
  logic              atEnd;

  assign atEnd = strobe.tick && (blankCnt == '0) && (cnt == activeLast);
  assign outEn = atEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      activeLast <= '0;
      blankCnt   <= '0;
    end else if (strobe.restart) begin
      cnt        <= '0;
      activeLast <= strobe.nextLast;
      blankCnt   <= BlankW'(BlankCycles);
    end else if (blankCnt != '0) begin
      blankCnt <= blankCnt - 1'b1;
    end else if (strobe.tick) begin
      if (cnt == activeLast) begin
        cnt        <= '0;
        activeLast <= strobe.nextLast;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && strobe.nextLast != '0) |=> !outEn);

  assert_blank_first_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> !outEn);

  assert_blank_second_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.restart) |=> !outEn);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= activeLast);
endmodule

// File: rtl/pow2_clk_prescaler.sv
module pow2_clk_prescaler
  import presc_pkg::*;
#(
  parameter int unsigned DataW = 32,
  parameter int unsigned AddrW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pllTick,
  input  logic               busTick,
  input  logic [AddrW-1:0]   regAddr,
  input  logic               regWrEn,
  input  logic [DataW/8-1:0] regByteEn,
  input  logic [DataW-1:0]   regWrData,
  output logic [DataW-1:0]   regRdData,
  output logic               outEn
);
  divStrobe_t strobe;

  presc_ctrl #(.DataW(DataW), .AddrW(AddrW)) uCtrl (
    .clk(clk), .rstN(rstN), .pllTick(pllTick), .busTick(busTick),
    .regAddr(regAddr), .regWrEn(regWrEn), .regByteEn(regByteEn),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe)
  );

  presc_divpath uDiv (
    .clk(clk), .rstN(rstN), .strobe(strobe), .outEn(outEn)
  );

  assert_en_on_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> strobe.tick);
endmodule

// File: tb/tb_pow2_clk_prescaler.sv
module tb_pow2_clk_prescaler;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pllTick = 1'b0, busTick = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        outEn;

  pow2_clk_prescaler dut (
    .clk(clk), .rstN(rstN), .pllTick(pllTick), .busTick(busTick),
    .regAddr(regAddr), .regWrEn(regWrEn), .regByteEn(regByteEn),
    .regWrData(regWrData), .regRdData(regRdData), .outEn(outEn)
  );

  always #(ClkPeriod/2) clk = ~clk;

  int checks = 0, errors = 0;
  // reference state
  logic [7:0] mCode; logic mSel, mErr;
  int mPend, mActive, mCnt, mBlank;
  logic [31:0] lastRd; logic lastOut;
  int cycle = 0, lastPulse = -1; bit gapOn = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRd(input int addr);
    if (addr == 0) return {24'h0, mCode};
    if (addr == 1) return {23'h0, mErr, 7'h0, mSel};
    return 32'h0;
  endfunction

  function automatic int lastOf(input logic [7:0] code);
    return (1 << code) - 1;
  endfunction

  task automatic step(input bit wr, input int addr, input logic [3:0] be,
                      input logic [31:0] data, input bit bus, input bit pll, input string tag);
    bit t, expOut;
    regWrEn = wr; regAddr = addr[3:0]; regByteEn = be; regWrData = data;
    busTick = bus; pllTick = pll;
    #1;
    t = mSel ? pll : bus;
    expOut = (mBlank == 0) && t && (mCnt == mActive);
    lastOut = outEn; lastRd = regRdData;
    check(outEn === expOut, {tag, " outEn"}, {31'h0, outEn}, {31'h0, expOut});
    check(regRdData === expRd(addr), {tag, " read"}, regRdData, expRd(addr));
    if (gapOn && outEn) begin
      if (lastPulse >= 0) begin
        int g = cycle - lastPulse;
        check(g == 1 || g == 2 || g == 4, "R8 gap", g, 4);
      end
      lastPulse = cycle;
    end
    // next state from the requirements
    if (wr && addr == 1 && be[0] && data[0] != mSel) begin
      mSel = data[0]; mBlank = 2; mCnt = 0; mActive = mPend;
    end else if (mBlank > 0) begin
      mBlank--;
    end else if (t) begin
      if (mCnt == mActive) begin mCnt = 0; mActive = mPend; end
      else mCnt++;
    end
    if (wr && addr == 0 && be[0]) begin
      if (data[7:0] <= 8'd2) begin mCode = data[7:0]; mPend = lastOf(data[7:0]); end
      else mErr = 1'b1;
    end
    if (wr && addr == 1 && be[1] && data[8]) mErr = 1'b0;
    cycle++;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input int n, input bit bus, input bit pll, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 4'h0, 32'h0, bus, pll, tag);
  endtask

  task automatic countIdle(input int n, input string tag, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step(0, 0, 4'h0, 32'h0, 1, 0, tag);
      cnt += int'(lastOut);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(ClkPeriod * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    mCode = 0; mSel = 0; mErr = 0; mPend = 0; mActive = 0; mCnt = 0; mBlank = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    step(0, 0, 4'h0, 32'h0, 0, 0, "R1");
    check(lastRd == 32'h0, "R1 div word", lastRd, 0);
    step(0, 1, 4'h0, 32'h0, 0, 0, "R1");
    check(lastRd == 32'h0, "R1 ctl word", lastRd, 0);

    // R2 divide by one follows tick
    countIdle(8, "R2", n);
    check(n == 8, "R2 continuous", n, 8);
    for (int i = 0; i < 12; i++) step(0, 0, 4'h0, 32'h0, i[0], 0, "R2");

    // R3 divide by two, four
    step(1, 0, 4'h1, 32'h1, 1, 0, "R3");
    idle(4, 1, 0, "R3");
    countIdle(16, "R3", n);
    check(n == 8, "R3 div2 pulses", n, 8);
    step(1, 0, 4'h1, 32'h2, 1, 0, "R3");
    idle(8, 1, 0, "R3");
    countIdle(16, "R3", n);
    check(n == 4, "R3 div4 pulses", n, 4);

    // R8 boundary-aligned changes
    gapOn = 1; lastPulse = -1;
    for (int k = 0; k < 24; k++) begin
      step(1, 0, 4'h1, {30'h0, 2'(k % 3)}, 1, 0, "R8");
      idle(k % 5 + 1, 1, 0, "R8");
    end
    gapOn = 0;

    // R4 invalid code kept, error raised
    step(1, 0, 4'h1, 32'h1, 1, 0, "R4");
    step(1, 0, 4'h1, 32'h5, 1, 0, "R4");
    step(0, 0, 4'h0, 32'h0, 1, 0, "R4");
    check(lastRd == 32'h1, "R4 code kept", lastRd, 1);
    step(0, 1, 4'h0, 32'h0, 1, 0, "R4");
    check(lastRd == 32'h100, "R4 error set", lastRd, 32'h100);

    // R5 sticky until write-one clear on lane 1
    step(1, 1, 4'h2, 32'h0, 1, 0, "R5");
    step(1, 0, 4'h1, 32'hFF, 1, 0, "R5");
    step(0, 1, 4'h0, 32'h0, 1, 0, "R5");
    check(lastRd == 32'h100, "R5 still set", lastRd, 32'h100);
    step(1, 1, 4'h2, 32'h100, 1, 0, "R5");
    step(0, 1, 4'h0, 32'h0, 1, 0, "R5");
    check(lastRd == 32'h0, "R5 cleared", lastRd, 0);

    // R6 reserved bits and unmapped words
    step(1, 0, 4'hF, 32'hABCD_FF02, 1, 0, "R6");
    step(0, 0, 4'h0, 32'h0, 1, 0, "R6");
    check(lastRd == 32'h2, "R6 div reserved", lastRd, 2);
    step(1, 1, 4'hF, 32'hFFFF_FEFE, 1, 0, "R6");
    step(0, 1, 4'h0, 32'h0, 1, 0, "R6");
    check(lastRd == 32'h0, "R6 ctl reserved", lastRd, 0);
    step(1, 3, 4'hF, 32'hFFFF_FFFF, 1, 0, "R6");
    step(0, 3, 4'h0, 32'h0, 1, 0, "R6");
    check(lastRd == 32'h0, "R6 unmapped", lastRd, 0);

    // R7 only lane 0 alters the code
    step(1, 0, 4'hE, 32'h0000_0001, 1, 0, "R7");
    step(0, 0, 4'h0, 32'h0, 1, 0, "R7");
    check(lastRd == 32'h2, "R7 lane gate", lastRd, 2);

    // R10 restart blanking, then R9 source select
    step(1, 0, 4'h1, 32'h0, 1, 1, "R10");
    idle(8, 1, 1, "R10");
    step(1, 1, 4'h1, 32'h1, 1, 1, "R10");
    step(0, 0, 4'h0, 32'h0, 1, 1, "R10");
    check(lastOut == 1'b0, "R10 blank 1", lastOut, 0);
    step(0, 0, 4'h0, 32'h0, 1, 1, "R10");
    check(lastOut == 1'b0, "R10 blank 2", lastOut, 0);
    step(0, 0, 4'h0, 32'h0, 1, 1, "R10");
    check(lastOut == 1'b1, "R10 resume", lastOut, 1);
    step(1, 1, 4'h1, 32'h1, 1, 1, "R10");
    step(0, 0, 4'h0, 32'h0, 1, 1, "R10");
    check(lastOut == 1'b1, "R10 no restart same sel", lastOut, 1);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      step(0, 0, 4'h0, 32'h0, 1, 0, "R9");
      n += int'(lastOut);
    end
    check(n == 0, "R9 bus tick ignored", n, 0);
    for (int i = 0; i < 40; i++) step(0, 0, 4'h0, 32'h0, 1, 1'($urandom_range(0, 1)), "R9");

    // random mix checked by the reference model
    for (int i = 0; i < 3000; i++) begin
      bit w = ($urandom_range(0, 9) == 0);
      int a = $urandom_range(0, 3);
      logic [31:0] d = $urandom;
      if ($urandom_range(0, 3) != 0) d[7:0] = 8'($urandom_range(0, 3));
      step(w, a, 4'($urandom), d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R8");
    end

    finish_run();
  end
endmodule